// File: doc/BRIEF.md
# Three-wire SPI register master

This block drives a radio transceiver whose serial port uses a single bidirectional data pin. A host issues one of four commands: a register write (one address byte and one data byte), a single-byte strobe, a single-byte register read, or a burst read of N bytes. The master frames each command in one active-low chip-select window. It drives the serial clock, and it drives the data pin through a separate output-enable. It releases the data pin when read bits are to be clocked in. Bytes that are read come back to the host one at a time over a valid/ready handshake.

The serial clock half-period comes from a divider input that is latched when a command is accepted. A busy flag tells the host when a new command can be taken. The bidirectional pin appears as three signals: output value, output enable and input value. The pad cell that joins them sits outside the block.

Top module: `spi3w_master`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the data pin is driven high with its enable set, busy is low and no read byte is offered.
- R2: Every byte is shifted most significant bit first with exactly eight clock pulses. A write (op code 0) sends the address byte and then the data byte.
- R3: The serial clock is low whenever chip select is high. The data output is set before each rising clock edge and holds its value through that edge.
- R4: Chip select goes low once per accepted command and stays low until the last byte of that command is complete, including every byte of a burst.
- R5: For a read (op code 2) or a burst read (op code 3), the address byte is sent with bit 6 forced to 1. For a write or a strobe (op code 1), the address byte is sent unchanged.
- R6: A strobe sends only its single command byte inside its chip-select window.
- R7: During the read bytes the data pin is released (enable low), and each read bit is captured at the system clock edge where the serial clock rises. While chip select is high, the pin is driven high again.
- R8: A burst read clocks in exactly cmd_len bytes after its address byte. A cmd_len of 0 is treated as 1. A single read clocks in one byte.
- R9: Each serial clock half-period lasts max(half_div, 2) system clocks, using the half_div value present when the command was accepted.
- R10: busy goes high in the cycle after a command is accepted and goes low in the same cycle that chip select returns high. A cmd_valid seen while busy starts no transaction.
- R11: Each read byte is offered on rd_data with rd_valid until rd_ready is seen. While the byte waits, the serial clock stays low, chip select stays low and rd_data holds its value.
- R12: After the data pin is released, at least one system clock passes with the serial clock low before the first read bit is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_op | input | 2 | 0 write, 1 strobe, 2 read, 3 burst read |
| cmd_addr | input | 8 | Address or strobe byte |
| cmd_wdata | input | 8 | Data byte for a write |
| cmd_len | input | LEN_W | Burst byte count (0 acts as 1) |
| half_div | input | DIV_W | Serial clock half-period in system clocks |
| busy | output | 1 | Transaction in progress |
| rd_valid | output | 1 | A read byte is offered |
| rd_ready | input | 1 | Host takes the offered byte |
| rd_data | output | 8 | Offered read byte |
| spi_csn | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_sdo | output | 1 | Data pin output value |
| spi_sdo_oe | output | 1 | Data pin output enable |
| spi_sdi | input | 1 | Data pin input value |

## Verification
The bench hunts for a missing or misplaced read flag: a design that ignores bit 6 would send 0x05 where 0x45 is due, and one that sets bit 6 on writes would corrupt a write address. It runs a 21-byte burst with a stall on the first byte, a zero-length burst and back-to-back reads. A design that drops chip select between bytes, miscounts the burst, or lets the clock run while the host stalls would produce too many or too few bytes in a window, or scrambled data. It also changes the divider and pokes cmd_valid while busy. A design that reads the divider live, or accepts a second command mid-transaction, shows wrong high-phase lengths or extra bytes on the wire.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_STROBE = 2'd1,
    OP_READ   = 2'd2,
    OP_BURST  = 2'd3
  } spi_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_HOLD   = 2'd2,
    ST_FINISH = 2'd3
  } spi_st_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RD_FLAG_BIT = 6;

endpackage

// File: rtl/spi3w_halfclk.sv
module spi3w_halfclk #(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned MIN_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             tick
);

  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_HALF);

  logic [DIV_W-1:0] div_q, div_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;

  assign tick = run && (cnt_q == (div_q - 1'b1));

  always_comb begin
    div_n = div_q;
    if (load) begin
      div_n = (div_in < MIN_V) ? MIN_V : div_in;
    end
    cnt_n = (!run || tick) ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= MIN_V;
      cnt_q <= '0;
    end else begin
      div_q <= div_n;
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/spi3w_shreg.sv
module spi3w_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);

  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (load) begin
      q_n = load_val;
    end else if (shift) begin
      q_n = {q[W-2:0], sin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

endmodule

// File: rtl/spi3w_ctrl.sv
module spi3w_ctrl
  import spi3w_pkg::*;
#(
  parameter int unsigned LEN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              tick,
  input  logic [7:0]        sh_q,
  input  logic              rd_ready,
  output logic              accept,
  output logic              clk_run,
  output logic              sh_load,
  output logic [7:0]        sh_val,
  output logic              sh_shift,
  output logic              busy,
  output logic              rd_valid,
  output logic              csn,
  output logic              sck,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam logic [LEN_W-1:0] ONE_LEN = LEN_W'(1);
  localparam int unsigned      BIT_W   = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  spi_st_e          state_q, state_n;
  logic             sck_q, sck_n;
  logic             csn_q, csn_n;
  logic             oe_q, oe_n;
  logic             phase_q, phase_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic [LEN_W-1:0] rx_left_q, rx_left_n;
  logic             tx_q, tx_n;
  logic             pend_q, pend_n;
  logic [7:0]       wdata_q, wdata_n;
  logic             is_rd;

  assign is_rd = (cmd_op == OP_READ) || (cmd_op == OP_BURST);

  always_comb begin
    state_n   = state_q;
    sck_n     = sck_q;
    csn_n     = csn_q;
    oe_n      = oe_q;
    phase_n   = phase_q;
    bit_n     = bit_q;
    rx_left_n = rx_left_q;
    tx_n      = tx_q;
    pend_n    = pend_q;
    wdata_n   = wdata_q;
    accept    = 1'b0;
    sh_load   = 1'b0;
    sh_val    = 8'h00;
    sh_shift  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          accept  = 1'b1;
          state_n = ST_SHIFT;
          csn_n   = 1'b0;
          sck_n   = 1'b0;
          oe_n    = 1'b1;
          phase_n = 1'b0;
          bit_n   = '0;
          tx_n    = 1'b1;
          sh_load = 1'b1;
          sh_val  = cmd_addr;
          if (is_rd) sh_val[RD_FLAG_BIT] = 1'b1;
          pend_n  = (cmd_op == OP_WRITE);
          wdata_n = cmd_wdata;
          if (cmd_op == OP_READ) begin
            rx_left_n = ONE_LEN;
          end else if (cmd_op == OP_BURST) begin
            rx_left_n = (cmd_len == '0) ? ONE_LEN : cmd_len;
          end else begin
            rx_left_n = '0;
          end
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!phase_q) begin
            sck_n   = 1'b1;
            phase_n = 1'b1;
            if (!tx_q) sh_shift = 1'b1;
          end else begin
            sck_n   = 1'b0;
            phase_n = 1'b0;
            bit_n   = bit_q + 1'b1;
            if (tx_q) sh_shift = 1'b1;
            if (bit_q == LAST_BIT) begin
              if (tx_q) begin
                if (pend_q) begin
                  sh_load = 1'b1;
                  sh_val  = wdata_q;
                  pend_n  = 1'b0;
                end else if (rx_left_q != '0) begin
                  tx_n = 1'b0;
                  oe_n = 1'b0;
                end else begin
                  state_n = ST_FINISH;
                end
              end else begin
                state_n = ST_HOLD;
              end
            end
          end
        end
      end
      ST_HOLD: begin
        if (rd_ready) begin
          rx_left_n = rx_left_q - 1'b1;
          if (rx_left_q == ONE_LEN) begin
            state_n = ST_FINISH;
            oe_n    = 1'b1;
          end else begin
            state_n = ST_SHIFT;
          end
        end
      end
      ST_FINISH: begin
        if (tick) begin
          state_n = ST_IDLE;
          csn_n   = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sck_q     <= 1'b0;
      csn_q     <= 1'b1;
      oe_q      <= 1'b1;
      phase_q   <= 1'b0;
      bit_q     <= '0;
      rx_left_q <= '0;
      tx_q      <= 1'b1;
      pend_q    <= 1'b0;
      wdata_q   <= 8'h00;
    end else begin
      state_q   <= state_n;
      sck_q     <= sck_n;
      csn_q     <= csn_n;
      oe_q      <= oe_n;
      phase_q   <= phase_n;
      bit_q     <= bit_n;
      rx_left_q <= rx_left_n;
      tx_q      <= tx_n;
      pend_q    <= pend_n;
      wdata_q   <= wdata_n;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign rd_valid = (state_q == ST_HOLD);
  assign clk_run  = (state_q == ST_SHIFT) || (state_q == ST_FINISH);
  assign csn      = csn_q;
  assign sck      = sck_q;
  assign sdo_oe   = oe_q;
  assign sdo      = ((state_q == ST_SHIFT) && tx_q) ? sh_q[BYTE_W-1] : 1'b1;

endmodule

// File: rtl/spi3w_master.sv
module spi3w_master
  import spi3w_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned LEN_W    = 5,
  parameter int unsigned MIN_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_addr,
  input  logic [7:0]       cmd_wdata,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [DIV_W-1:0] half_div,
  output logic             busy,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             spi_csn,
  output logic             spi_sck,
  output logic             spi_sdo,
  output logic             spi_sdo_oe,
  input  logic             spi_sdi
);

  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic       tick, accept, clk_run;
  logic       sh_load, sh_shift;
  logic [7:0] sh_val, sh_q;

  spi3w_halfclk #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_half (
    .clk(clk), .rst_n(rst_int_n), .load(accept), .div_in(half_div),
    .run(clk_run), .tick(tick)
  );

  spi3w_shreg #(.W(BYTE_W)) u_shreg (
    .clk(clk), .rst_n(rst_int_n), .load(sh_load), .load_val(sh_val),
    .shift(sh_shift), .sin(spi_sdi), .q(sh_q)
  );

  spi3w_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
    .tick(tick), .sh_q(sh_q), .rd_ready(rd_ready), .accept(accept),
    .clk_run(clk_run), .sh_load(sh_load), .sh_val(sh_val),
    .sh_shift(sh_shift), .busy(busy), .rd_valid(rd_valid),
    .csn(spi_csn), .sck(spi_sck), .sdo(spi_sdo), .sdo_oe(spi_sdo_oe)
  );

  assign rd_data = sh_q;

endmodule

// File: rtl/spi3w_master_chk.sv
module spi3w_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       spi_csn,
  input logic       spi_sck,
  input logic       spi_sdo,
  input logic       spi_sdo_oe
);

  // R3
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_sck);

  // R3
  sdo_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(spi_sck) && spi_sdo_oe) |-> $stable(spi_sdo));

  // R7
  idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> (spi_sdo_oe && spi_sdo));

  // R10
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_csn);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R11
  stall_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!spi_sck && !spi_csn));

  // R12
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sdo_oe) |=> !spi_sck);

endmodule

bind spi3w_master spi3w_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .spi_csn(spi_csn),
  .spi_sck(spi_sck), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe)
);

// File: tb/sim_spi3w_master.sv
`timescale 1ns/1ps
module sim_spi3w_master;

  localparam int DIV_W = 8;
  localparam int LEN_W = 5;

  logic             clk;
  logic             rst_n;
  logic             cmd_valid;
  logic [1:0]       cmd_op;
  logic [7:0]       cmd_addr, cmd_wdata;
  logic [LEN_W-1:0] cmd_len;
  logic [DIV_W-1:0] half_div;
  logic             busy, rd_valid, rd_ready;
  logic [7:0]       rd_data;
  logic             spi_csn, spi_sck, spi_sdo, spi_sdo_oe, spi_sdi;

  spi3w_master #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
    .half_div(half_div), .busy(busy), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .spi_csn(spi_csn),
    .spi_sck(spi_sck), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .spi_sdi(spi_sdi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int windows = 0;
  int exp_windows = 0;
  int cur_half = 2;
  int stall_rem = 0;

  logic [7:0] exp_tx_q[$];
  logic [7:0] slv_q[$];
  logic [7:0] rd_exp_q[$];
  int         win_tx_q[$];
  int         win_rx_q[$];
  bit         win_flag_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] addr,
                       input logic [7:0] wd, input int len, input int div,
                       input int seed, input bit poke);
    logic [7:0] first;
    int nrx;
    while (busy) @(negedge clk);
    cur_half = (div < 2) ? 2 : div;
    first = addr;
    if (op >= 2) first[6] = 1'b1;
    exp_tx_q.push_back(first);
    if (op == 0) exp_tx_q.push_back(wd);
    nrx = (op == 2) ? 1 : (op == 3) ? ((len == 0) ? 1 : len) : 0;
    for (int k = 0; k < nrx; k++) begin
      slv_q.push_back(8'((seed + k * 37) & 8'hFF));
      rd_exp_q.push_back(8'((seed + k * 37) & 8'hFF));
    end
    win_tx_q.push_back((op == 0) ? 2 : 1);
    win_rx_q.push_back(nrx);
    win_flag_q.push_back(first[6]);
    exp_windows++;
    cmd_op = op; cmd_addr = addr; cmd_wdata = wd;
    cmd_len = LEN_W'(len); half_div = DIV_W'(div);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    half_div = 8'd7;
    // R10: busy raised and chip select low right after acceptance
    chk(busy && !spi_csn, "R10", {busy, spi_csn}, 2'b10);
    if (poke) begin
      cmd_op = 2'd1; cmd_addr = 8'h99; cmd_valid = 1'b1;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  // scoreboard monitor on the wire
  logic [7:0] txsh, sbyte, first_byte;
  int txb, rxb, win_tx, win_rx, hcnt, sbit;
  bit first_seen;
  logic prev_csn = 1'b1, prev_sck = 1'b0, prev_oe = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!spi_csn && prev_csn) begin
        txb = 0; rxb = 0; win_tx = 0; win_rx = 0; first_seen = 0;
      end
      if (!spi_sdo_oe && prev_oe) begin
        sbit = 7;
        sbyte = (slv_q.size() > 0) ? slv_q.pop_front() : 8'h00;
        spi_sdi = sbyte[7];
      end
      if (!spi_csn && spi_sck && !prev_sck) begin
        if (spi_sdo_oe) begin
          txsh = {txsh[6:0], spi_sdo};
          txb++;
          if (txb == 8) begin
            txb = 0; win_tx++;
            if (!first_seen) first_byte = txsh;
            first_seen = 1;
            if (exp_tx_q.size() == 0) chk(0, "R2", txsh, 0);
            else begin
              logic [7:0] e;
              e = exp_tx_q.pop_front();
              // R2: byte on the wire, MSB first
              chk(txsh == e, "R2", txsh, e);
            end
          end
        end else begin
          rxb++;
          if (rxb == 8) begin rxb = 0; win_rx++; end
          sbit--;
          if (sbit < 0) begin
            sbit = 7;
            sbyte = (slv_q.size() > 0) ? slv_q.pop_front() : 8'h00;
          end
          spi_sdi = sbyte[sbit];
        end
      end
      if (spi_sck) hcnt++;
      else if (prev_sck) begin
        // R9: high phase length equals latched half-period
        chk(hcnt == cur_half, "R9", hcnt, cur_half);
        hcnt = 0;
      end
      if (spi_csn && !prev_csn) begin
        int et, er;
        bit ef;
        windows++;
        et = (win_tx_q.size() > 0) ? win_tx_q.pop_front() : -1;
        er = (win_rx_q.size() > 0) ? win_rx_q.pop_front() : -1;
        ef = (win_flag_q.size() > 0) ? win_flag_q.pop_front() : 1'b0;
        chk(!busy, "R10", busy, 0);
        // R4 R6: bytes sent inside one window
        chk(win_tx == et, "R4,R6", win_tx, et);
        // R7 R8: bytes clocked in with the pin released
        chk(win_rx == er, "R7,R8", win_rx, er);
        // R5: read flag on the address byte
        chk(first_byte[6] == ef, "R5", first_byte, ef);
        chk(spi_sdo_oe && spi_sdo, "R7", {spi_sdo_oe, spi_sdo}, 2'b11);
      end
      prev_csn = spi_csn; prev_sck = spi_sck; prev_oe = spi_sdo_oe;
    end
  end

  // read-data sink
  logic [7:0] stall_data;
  bit stall_first = 1;
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (stall_rem > 0) begin
        if (stall_first) stall_data = rd_data;
        stall_first = 0;
        rd_ready = 1'b0;
        stall_rem--;
        // R11: clock parked, window open, data held while stalled
        chk(!spi_sck && !spi_csn && rd_data == stall_data, "R11",
            {spi_sck, spi_csn, rd_data}, {2'b00, stall_data});
      end else begin
        logic [7:0] e;
        rd_ready = 1'b1;
        stall_first = 1;
        e = (rd_exp_q.size() > 0) ? rd_exp_q.pop_front() : 8'hxx;
        // R7 R11: byte delivered on the handshake
        chk(rd_data === e, "R7,R11", rd_data, e);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_addr = 8'h00;
    cmd_wdata = 8'h00; cmd_len = '0; half_div = 8'd2; rd_ready = 1'b1;
    spi_sdi = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle levels after reset
    chk(spi_csn && !spi_sck && spi_sdo_oe && spi_sdo && !busy && !rd_valid,
        "R1", {spi_csn, spi_sck, spi_sdo_oe, spi_sdo, busy, rd_valid}, 6'b101100);

    issue(2'd0, 8'h0F, 8'hA0, 0, 2, 0, 0);   // write
    issue(2'd1, 8'hC0, 8'h00, 0, 3, 0, 0);   // strobe keeps its own bit 6
    issue(2'd2, 8'h02, 8'h00, 0, 2, 8'h5A, 0); // single read
    issue(2'd0, 8'h2A, 8'h3C, 0, 5, 0, 1);   // write with a poke while busy
    stall_rem = 10;
    issue(2'd3, 8'h45, 8'h00, 21, 2, 8'h07, 0); // 21-byte burst, first byte stalled
    issue(2'd3, 8'h05, 8'h00, 0, 0, 8'hC3, 0);  // zero length burst, div below min
    issue(2'd3, 8'h46, 8'h00, 3, 1, 8'h81, 0);  // short burst
    issue(2'd2, 8'h00, 8'h00, 0, 4, 8'hFE, 0);  // read at slower clock
    issue(2'd1, 8'h20, 8'h00, 0, 6, 0, 0);      // strobe without bit 6

    repeat (20) @(negedge clk);
    // R10: the poked command never opened a window
    chk(windows == exp_windows && spi_csn, "R10", windows, exp_windows);
    chk(exp_tx_q.size() == 0 && rd_exp_q.size() == 0, "R2",
        exp_tx_q.size() + rd_exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule